// File: doc/BRIEF.md
# Prefix-Coded Instruction Boundary Decoder

This block takes a stream of 32-bit instruction-memory words and groups them into whole instructions. Each word announces its own role through its top bits. A word with the top bit set opens an instruction. The run of ones at its top, counted up to the first zero, gives the total instruction length in words, with the opening word included. A word with the top bit clear is never a start. It is either a payload word of the open instruction, or free data placed in the code, such as a jump table or a wide constant. Free data is dropped without stalling the stream.

Because any word with its top bit set is a start candidate, the decoder can find boundaries from any position without looking at opcodes. If a new start shows up while payload is still owed, the partial instruction is emitted with an error flag, and decoding continues at once from the new start. Words arrive on a valid/ready stream. Instructions leave one per handshake and carry their length, the opening word, up to three payload words, the number of data words skipped in front of them, and an error bit. A separate combinational helper marks the start candidates across a four-word fetch window.

Top module: `instr_boundary_decoder`

## Requirements
- R1: A word with bit 31 set opens an instruction whose length L (1 to 4) equals its count of leading ones. After the opening word and L-1 further words with bit 31 clear, one record is emitted with out_len = L, out_leader = the opening word and out_err = 0.
- R2: A word with bit 31 clear that arrives while no payload is owed produces no output and never lowers in_ready. The number of such words since the previous opening word is reported in out_skip of the next record, and the count restarts from zero at each opening word.
- R3: The skip count saturates at 65535 and does not wrap.
- R4: An opening word with 5 or more leading ones, all-ones included, yields a record with out_err = 1, out_len = 0 and the word in out_leader. Following words with bit 31 clear are then counted as skipped data.
- R5: An opening word that arrives while payload is still owed causes the partial instruction to be emitted with out_err = 1 and out_len = the number of words it collected. The new word then opens the next instruction.
- R6: While out_valid is high and out_ready is low, every output field holds steady and in_ready is low. in_ready is low only while a finished record waits, either in the output register or staged inside the block.
- R7: Payload word k (k = 0, 1, 2, the (k+1)-th word after the opening word) appears at out_payload[32k+31:32k]. Slots beyond the collected words read zero.
- R8: When the truncation of R5 is caused by a one-word or illegal opening word, that word's own record is delivered in the handshake right after the truncated record.
- R9: win_mask[i] equals bit 31 of lane i of win_words, where lane i is win_words[32i+31:32i], in the same cycle.
- R10: A synchronous reset clears out_valid, drops any partial instruction, zeroes the skip count and leaves in_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_word | input | 32 | Instruction-memory word |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer takes the record |
| out_len | output | 3 | Instruction length in words (0 for an illegal opening word) |
| out_leader | output | 32 | Opening word |
| out_payload | output | 96 | Payload words, slot 0 in the low bits |
| out_skip | output | 16 | Data words skipped before this instruction |
| out_err | output | 1 | Truncated or illegal-length instruction |
| win_words | input | 128 | Four-word fetch window, lane 0 in the low bits |
| win_mask | output | 4 | Start-candidate mark for each lane |

## Verification
On every cycle the assertions check the following: the output stays frozen under back-pressure, in_ready stays low while a record is pending, every emitted opening word has its top bit set, a clean record has a length from 1 to 4, a length-0 record is flagged, a lone data word emits nothing, and the skip count stays at its ceiling once it reaches it. Only the bench scenarios show the values themselves: that the length matches the count of leading ones, that payload words land in the right slots, the truncation and staging order, the skip totals across data bursts and resets, and the window mask.

// File: rtl/ibd_pkg.sv
package ibd_pkg;
  // Assembly register state: empty, collecting payload, holding a finished record
  typedef enum logic [1:0] {
    ASM_IDLE = 2'd0,
    ASM_FILL = 2'd1,
    ASM_HELD = 2'd2
  } asm_state_e;
endpackage

// File: rtl/ibd_lead_ones.sv
module ibd_lead_ones #(
  parameter int SCAN  = 5,
  parameter int CNT_W = 3
) (
  input  logic [SCAN-1:0]  top_bits,   // MSB first slice of the word
  output logic [CNT_W-1:0] ones
);
  logic run;
  always_comb begin
    run  = 1'b1;
    ones = '0;
    for (int i = 0; i < SCAN; i++) begin
      if (run && top_bits[SCAN-1-i]) ones = ones + CNT_W'(1);
      else run = 1'b0;
    end
  end
endmodule

// File: rtl/ibd_skip_ctr.sv
module ibd_skip_ctr #(
  parameter int SKIP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              clr,
  output logic [SKIP_W-1:0] count
);
  localparam logic [SKIP_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)        count <= '0;
    else if (inc && count != TOP) count <= count + SKIP_W'(1);
  end

  // R3
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (count == TOP && !clr) |=> (count == TOP));
endmodule

// File: rtl/ibd_lane_mask.sv
module ibd_lane_mask #(
  parameter int WORD_W = 32,
  parameter int LANES  = 4
) (
  input  logic [LANES*WORD_W-1:0] words,
  output logic [LANES-1:0]        mask
);
  logic low_bits_unused;
  assign low_bits_unused = ^words;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask[g] = words[g*WORD_W + WORD_W - 1];
  end
endmodule

// File: rtl/instr_boundary_decoder.sv
module instr_boundary_decoder
  import ibd_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int MAX_LEN = 4,
  parameter int SKIP_W  = 16,
  parameter int LANES   = 4,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int PAY_N  = MAX_LEN - 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [WORD_W-1:0]       in_word,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LEN_W-1:0]        out_len,
  output logic [WORD_W-1:0]       out_leader,
  output logic [PAY_N*WORD_W-1:0] out_payload,
  output logic [SKIP_W-1:0]       out_skip,
  output logic                    out_err,
  input  logic [LANES*WORD_W-1:0] win_words,
  output logic [LANES-1:0]        win_mask
);
  localparam int SCAN  = MAX_LEN + 1;
  localparam int CNT_W = $clog2(SCAN + 1);

  // Assembly registers
  asm_state_e        st_q;
  logic [LEN_W-1:0]  asm_len_q, asm_cnt_q;
  logic              asm_ill_q;
  logic [WORD_W-1:0] lead_q;
  logic [WORD_W-1:0] pay_q [PAY_N];
  logic [SKIP_W-1:0] asm_skip_q;

  // Decode of the incoming word
  logic [CNT_W-1:0]  ones;
  logic              top, ill, new_done, acc;
  logic [LEN_W-1:0]  new_len, cnt_inc;
  logic [SKIP_W-1:0] skip_cnt;

  ibd_lead_ones #(.SCAN(SCAN), .CNT_W(CNT_W)) u_ones (
    .top_bits (in_word[WORD_W-1 -: SCAN]),
    .ones     (ones)
  );

  assign top      = in_word[WORD_W-1];
  assign ill      = (ones > CNT_W'(MAX_LEN));
  assign new_len  = ill ? '0 : LEN_W'(ones);
  assign new_done = ill || (new_len == LEN_W'(1));
  assign cnt_inc  = asm_cnt_q + LEN_W'(1);
  assign in_ready = !out_valid && (st_q != ASM_HELD);
  assign acc      = in_valid && in_ready;

  ibd_skip_ctr #(.SKIP_W(SKIP_W)) u_skip (
    .clk   (clk),
    .rst   (rst),
    .inc   (acc && !top && st_q == ASM_IDLE),
    .clr   (acc && top),
    .count (skip_cnt)
  );

  ibd_lane_mask #(.WORD_W(WORD_W), .LANES(LANES)) u_mask (
    .words (win_words),
    .mask  (win_mask)
  );

  // Flattened payload: as held, and with the incoming word placed in its slot
  logic [PAY_N*WORD_W-1:0] pay_flat, pay_flat_app;
  for (genvar g = 0; g < PAY_N; g++) begin : g_pay
    assign pay_flat[g*WORD_W +: WORD_W]     = pay_q[g];
    assign pay_flat_app[g*WORD_W +: WORD_W] =
      (asm_cnt_q == LEN_W'(g + 1)) ? in_word : pay_q[g];
  end

  // Record selection
  logic                    emit;
  logic [LEN_W-1:0]        em_len;
  logic [WORD_W-1:0]       em_lead;
  logic [PAY_N*WORD_W-1:0] em_pay;
  logic [SKIP_W-1:0]       em_skip;
  logic                    em_err;

  always_comb begin
    emit    = 1'b0;
    em_len  = asm_len_q;
    em_lead = lead_q;
    em_pay  = pay_flat;
    em_skip = asm_skip_q;
    em_err  = asm_ill_q;
    if (st_q == ASM_HELD && !out_valid) begin
      emit = 1'b1;
    end else if (acc && !top && st_q == ASM_FILL && cnt_inc == asm_len_q) begin
      emit   = 1'b1;
      em_pay = pay_flat_app;
      em_err = 1'b0;
    end else if (acc && top && st_q == ASM_FILL) begin
      emit   = 1'b1;
      em_len = asm_cnt_q;
      em_err = 1'b1;
    end else if (acc && top && st_q == ASM_IDLE && new_done) begin
      emit    = 1'b1;
      em_len  = new_len;
      em_lead = in_word;
      em_pay  = '0;
      em_skip = skip_cnt;
      em_err  = ill;
    end
  end

  // Output register
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_len     <= '0;
      out_leader  <= '0;
      out_payload <= '0;
      out_skip    <= '0;
      out_err     <= 1'b0;
    end else if (emit) begin
      out_valid   <= 1'b1;
      out_len     <= em_len;
      out_leader  <= em_lead;
      out_payload <= em_pay;
      out_skip    <= em_skip;
      out_err     <= em_err;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  // Assembly register
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ASM_IDLE;
      asm_len_q  <= '0;
      asm_cnt_q  <= '0;
      asm_ill_q  <= 1'b0;
      lead_q     <= '0;
      asm_skip_q <= '0;
      for (int i = 0; i < PAY_N; i++) pay_q[i] <= '0;
    end else if (st_q == ASM_HELD) begin
      if (!out_valid) st_q <= ASM_IDLE;
    end else if (acc && !top) begin
      if (st_q == ASM_FILL) begin
        for (int i = 0; i < PAY_N; i++)
          if (asm_cnt_q == LEN_W'(i + 1)) pay_q[i] <= in_word;
        asm_cnt_q <= cnt_inc;
        if (cnt_inc == asm_len_q) st_q <= ASM_IDLE;
      end
    end else if (acc && top) begin
      lead_q     <= in_word;
      asm_len_q  <= new_len;
      asm_cnt_q  <= LEN_W'(1);
      asm_ill_q  <= ill;
      asm_skip_q <= skip_cnt;
      for (int i = 0; i < PAY_N; i++) pay_q[i] <= '0;
      if (st_q == ASM_FILL) st_q <= new_done ? ASM_HELD : ASM_FILL;
      else                  st_q <= new_done ? ASM_IDLE : ASM_FILL;
    end
  end

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_leader) &&
      $stable(out_len) && $stable(out_payload) && $stable(out_skip) && $stable(out_err)));
  // R6
  ready_low_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);
  // R1
  leader_top_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_leader[WORD_W-1]);
  // R1
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err) |-> (out_len != '0 && out_len <= LEN_W'(MAX_LEN)));
  // R4
  ill_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_len == '0) |-> out_err);
  // R7
  pay_top_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err && out_len >= LEN_W'(2)) |-> !out_payload[WORD_W-1]);
  // R2
  data_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !top && st_q == ASM_IDLE) |=> !out_valid);
endmodule

// File: tb/sim_instr_boundary_decoder.sv
`timescale 1ns/1ps
module sim_instr_boundary_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [2:0]  out_len;
  logic [31:0] out_leader;
  logic [95:0] out_payload;
  logic [15:0] out_skip;
  logic        out_err;
  logic [127:0] win_words = '0;
  logic [3:0]  win_mask;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  instr_boundary_decoder u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_len(out_len),
    .out_leader(out_leader), .out_payload(out_payload), .out_skip(out_skip),
    .out_err(out_err), .win_words(win_words), .win_mask(win_mask)
  );

  task automatic check(string req, string what, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(logic [31:0] w);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic get_rec(string req, logic [2:0] len, logic [31:0] lead,
                         logic [95:0] pay, logic [15:0] skip, logic err);
    while (!out_valid) @(negedge clk);
    check(req, "len", out_len, len);
    check(req, "leader", out_leader, lead);
    check(req, "payload", out_payload, pay);
    check(req, "skip", out_skip, skip);
    check(req, "err", out_err, err);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // R10
  task automatic t_reset_state();
    do_reset();
    check("R10", "out_valid after reset", out_valid, 0);
    check("R10", "in_ready after reset", in_ready, 1);
  endtask

  // R1 / R7: every legal length
  task automatic t_lengths();
    send(32'h8000_0011);
    get_rec("R1", 3'd1, 32'h8000_0011, 96'h0, 16'd0, 1'b0);
    send(32'hC000_0022); send(32'h0000_00A1);
    get_rec("R1", 3'd2, 32'hC000_0022, {64'h0, 32'h0000_00A1}, 16'd0, 1'b0);
    send(32'hE000_0033); send(32'h0000_00B1); send(32'h0000_00B2);
    get_rec("R7", 3'd3, 32'hE000_0033, {32'h0, 32'h0000_00B2, 32'h0000_00B1}, 16'd0, 1'b0);
    send(32'hF000_0044); send(32'h0000_0001); send(32'h0000_0002); send(32'h0000_0003);
    get_rec("R7", 3'd4, 32'hF000_0044, {32'h3, 32'h2, 32'h1}, 16'd0, 1'b0);
  endtask

  // R2: embedded data skipped and counted
  task automatic t_embedded_data();
    send(32'h1234_5678); send(32'h0000_0000); send(32'h7FFF_FFFF);
    check("R2", "no record from data", out_valid, 0);
    check("R2", "ready after data", in_ready, 1);
    send(32'hC000_0055); send(32'h0000_0C01);
    get_rec("R2", 3'd2, 32'hC000_0055, {64'h0, 32'h0000_0C01}, 16'd3, 1'b0);
    send(32'h8000_0066);
    get_rec("R2", 3'd1, 32'h8000_0066, 96'h0, 16'd0, 1'b0);
  endtask

  // R5: truncation by a multi-word leader
  task automatic t_truncate();
    send(32'hE000_0077); send(32'h0000_0D01);
    send(32'hC000_0088);
    get_rec("R5", 3'd2, 32'hE000_0077, {64'h0, 32'h0000_0D01}, 16'd0, 1'b1);
    send(32'h0000_0D02);
    get_rec("R5", 3'd2, 32'hC000_0088, {64'h0, 32'h0000_0D02}, 16'd0, 1'b0);
  endtask

  // R8 / R6: truncation by a one-word leader, staged record, back-pressure
  task automatic t_truncate_staged();
    logic [31:0] held_lead;
    send(32'hF000_0099);
    send(32'h8000_00AA);
    check("R6", "in_ready low while records wait", in_ready, 0);
    held_lead = out_leader;
    repeat (3) @(negedge clk);
    check("R6", "leader held under back-pressure", out_leader, held_lead);
    check("R6", "valid held under back-pressure", out_valid, 1);
    get_rec("R8", 3'd1, 32'hF000_0099, 96'h0, 16'd0, 1'b1);
    get_rec("R8", 3'd1, 32'h8000_00AA, 96'h0, 16'd0, 1'b0);
    check("R6", "ready back after drain", in_ready, 1);
  endtask

  // R4: illegal length leaders
  task automatic t_illegal();
    send(32'hF800_0000);
    get_rec("R4", 3'd0, 32'hF800_0000, 96'h0, 16'd0, 1'b1);
    send(32'h0000_0001); send(32'h0000_0002);
    send(32'hFFFF_FFFF);
    get_rec("R4", 3'd0, 32'hFFFF_FFFF, 96'h0, 16'd2, 1'b1);
    send(32'h0000_0003);
    send(32'h8000_00BB);
    get_rec("R4", 3'd1, 32'h8000_00BB, 96'h0, 16'd1, 1'b0);
    // illegal leader interrupting a partial instruction
    send(32'hC000_00CC); send(32'hFC00_0000);
    get_rec("R8", 3'd1, 32'hC000_00CC, 96'h0, 16'd0, 1'b1);
    get_rec("R4", 3'd0, 32'hFC00_0000, 96'h0, 16'd0, 1'b1);
  endtask

  // R3 / R2: long data run, saturation, no stall
  task automatic t_saturate();
    int stalls = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = 32'h0BAD_F00D;
    repeat (65540) begin
      @(negedge clk);
      if (!in_ready) stalls++;
    end
    in_valid = 1'b0;
    check("R2", "stalls during data run", stalls, 0);
    send(32'h8000_00DD);
    get_rec("R3", 3'd1, 32'h8000_00DD, 96'h0, 16'hFFFF, 1'b0);
    send(32'h8000_00EE);
    get_rec("R3", 3'd1, 32'h8000_00EE, 96'h0, 16'd0, 1'b0);
  endtask

  // R10: reset drops a partial instruction and the skip count
  task automatic t_reset_mid();
    send(32'h0000_0009);
    send(32'hF000_0101); send(32'h0000_0001);
    do_reset();
    check("R10", "no record after mid reset", out_valid, 0);
    send(32'h0000_0005);
    send(32'h8000_0102);
    get_rec("R10", 3'd1, 32'h8000_0102, 96'h0, 16'd1, 1'b0);
  endtask

  // R9: window mask
  task automatic t_window();
    win_words = {32'h8000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFF};
    #1 check("R9", "mask pattern A", win_mask, 4'b1010);
    win_words = {32'h0000_0001, 32'hC000_0000, 32'h0FFF_FFFF, 32'h8000_0000};
    #1 check("R9", "mask pattern B", win_mask, 4'b0101);
    win_words = {4{32'h9000_0000}};
    #1 check("R9", "mask all set", win_mask, 4'b1111);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_window();
    t_lengths();
    t_embedded_data();
    t_truncate();
    t_truncate_staged();
    t_illegal();
    t_reset_mid();
    t_saturate();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule